// File: doc/BRIEF.md
# Configurable ADC Result Serial Readout

This block sits between a converter's result path and its serial host port. Each time a 24-bit signed conversion result arrives with its valid strobe, the block optionally clamps it to non-negative values and optionally recodes it as offset binary. It then keeps the outcome in a three-byte output data register. The conversion result itself is never altered. Only this output copy is affected.

A host starts a read with a start pulse, a start byte address and a byte count. It then clocks the bytes out with a serial clock. Configuration inputs choose the direction of the byte addresses, the bit order within each byte, and which pin carries the data. The data can go to a shared bidirectional pin or to a dedicated output pin, and each pin has its own output enable. The serial clock is sampled by the system clock, so it must run well below the system clock rate.

A result that arrives while a read is running is held back and loaded once the read ends. Every multi-byte read therefore returns bytes from a single conversion.

Top module: `ro_serial_readout`

## Requirements
- R1: With `cfg_offset_i` low, the register holds two's complement. An input of 0x7FFFFF reads 0x7FFFFF, 0x000000 reads 0x000000 and 0x800000 reads 0x800000.
- R2: With `cfg_offset_i` high, the register holds offset binary, which is the clamped value with bit 23 inverted. 0x7FFFFF reads 0xFFFFFF, 0x000000 reads 0x800000 and 0x800000 reads 0x000000.
- R3: With `cfg_unipolar_i` high, a negative result (bit 23 set) is replaced by zero before formatting. It therefore reads 0x000000 in two's complement and 0x800000 in offset binary. Non-negative results pass unchanged.
- R4: Format and clamp are taken from the configuration at the moment each result is loaded. The conversion loaded right after `cfg_unipolar_i` is cleared reads as a normal bipolar value.
- R5: Byte address 0 holds bits 23:16, address 1 holds bits 15:8 and address 2 holds bits 7:0. Address 3 reads 0x00. With `cfg_lsb_byte_first_i` low, each further byte of a read comes from the next higher address, wrapping modulo 4.
- R6: With `cfg_lsb_byte_first_i` high, each further byte comes from the next lower address, wrapping modulo 4.
- R7: With `cfg_lsb_bit_first_i` low, each byte is sent bit 7 first. With it high, each byte is sent bit 0 first.
- R8: With `cfg_use_sdo_i` low, data and enable appear on `sdio_o`/`sdio_oe_o`, and `sdo_oe_o` stays low. With it high, they appear on `sdo_o`/`sdo_oe_o`, and `sdio_oe_o` stays low. The two enables are never high together.
- R9: The output register is not reloaded while a read is in progress. A result that arrives during a read is loaded after the read ends.
- R10: Enables and data are low while no read runs. The first bit appears within two clocks of an accepted start. The data bit changes only after a falling serial clock edge. The enable drops after the falling edge that follows the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| result_i | input | 24 | Signed conversion result |
| result_vld_i | input | 1 | Result valid strobe, one clock |
| cfg_offset_i | input | 1 | 1 = offset binary, 0 = two's complement |
| cfg_unipolar_i | input | 1 | 1 = clamp negative results to zero |
| cfg_lsb_byte_first_i | input | 1 | 1 = descending byte addresses |
| cfg_lsb_bit_first_i | input | 1 | 1 = bit 0 of each byte first |
| cfg_use_sdo_i | input | 1 | 1 = dedicated output pin, 0 = shared pin |
| rd_start_i | input | 1 | Start a read (ignored while busy or if count is 0) |
| rd_addr_i | input | 2 | Start byte address |
| rd_count_i | input | 3 | Number of bytes to read |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_o | output | 1 | Shared pin data |
| sdio_oe_o | output | 1 | Shared pin output enable |
| sdo_o | output | 1 | Dedicated pin data |
| sdo_oe_o | output | 1 | Dedicated pin output enable |

## Verification
The hardest situation to reach from the ports is a new result arriving in the middle of a multi-byte read. The stimulus starts a three-byte read and pulses the valid strobe with a different value after ten serial bits. It then checks that all three bytes still come from the earlier value, and that the following read returns the new one. Wrapped addresses in both directions are reached with start addresses near the ends of the map. Clamping is checked in both number formats, with a bipolar load directly after clamping is switched off.

// File: rtl/ro_readout_pkg.sv
package ro_readout_pkg;
  typedef struct packed {
    logic lsb_byte_first;
    logic lsb_bit_first;
    logic use_sdo;
  } rd_cfg_t;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = 3;
endpackage

// File: rtl/ro_format.sv
module ro_format #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              vld_i,
  input  logic              offset_i,
  input  logic              unipolar_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] dor_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] pend_q;
  logic              pend_v_q;

  always_comb begin
    clamped = (unipolar_i && res_i[MSB]) ? '0 : res_i;
    coded   = {clamped[MSB] ^ offset_i, clamped[MSB-1:0]};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dor_o    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (vld_i && hold_i) begin
      pend_q   <= coded;
      pend_v_q <= 1'b1;
    end else if (vld_i) begin
      dor_o    <= coded;
      pend_v_q <= 1'b0;
    end else if (!hold_i && pend_v_q) begin
      dor_o    <= pend_q;
      pend_v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ro_bytesel.sv
module ro_bytesel #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 2
) (
  input  logic [DATA_W-1:0] dor_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);
  localparam int NBYTES = DATA_W / 8;

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr_i == ADDR_W'(i)) byte_o = dor_i[DATA_W-1-8*i -: 8];
    end
  end
endmodule

// File: rtl/ro_shifter.sv
module ro_shifter
  import ro_readout_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  rd_cfg_t           cfg_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] look_addr_o,
  output logic              hold_o,
  output logic              busy_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic                 sclk_d;
  logic                 fall;
  logic                 start_go;
  logic [ADDR_W-1:0]    addr_q, n_addr;
  logic [BIT_IDX_W-1:0] bit_q, n_bit;
  logic [CNT_W-1:0]     rem_q, n_rem;
  logic                 n_busy;
  rd_cfg_t              cfg_q, n_cfg;
  logic                 bit_val;

  assign fall     = sclk_d & ~sclk_i;
  assign start_go = start_i & ~busy_o & (count_i != '0);
  assign hold_o   = busy_o | start_go;

  always_comb begin
    n_busy = busy_o;
    n_addr = addr_q;
    n_bit  = bit_q;
    n_rem  = rem_q;
    n_cfg  = cfg_q;
    if (start_go) begin
      n_busy = 1'b1;
      n_addr = start_addr_i;
      n_bit  = '0;
      n_rem  = count_i;
      n_cfg  = cfg_i;
    end else if (busy_o && fall) begin
      if (bit_q == BIT_IDX_W'(7)) begin
        if (rem_q == CNT_W'(1)) begin
          n_busy = 1'b0;
        end else begin
          n_addr = cfg_q.lsb_byte_first ? addr_q - 1'b1 : addr_q + 1'b1;
          n_bit  = '0;
          n_rem  = rem_q - 1'b1;
        end
      end else begin
        n_bit = bit_q + 1'b1;
      end
    end
  end

  assign look_addr_o = n_addr;
  assign bit_val = n_cfg.lsb_bit_first ? byte_i[n_bit] : byte_i[3'd7 - n_bit];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sclk_d    <= 1'b0;
      busy_o    <= 1'b0;
      addr_q    <= '0;
      bit_q     <= '0;
      rem_q     <= '0;
      cfg_q     <= '0;
      sdio_o    <= 1'b0;
      sdio_oe_o <= 1'b0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else begin
      sclk_d    <= sclk_i;
      busy_o    <= n_busy;
      addr_q    <= n_addr;
      bit_q     <= n_bit;
      rem_q     <= n_rem;
      cfg_q     <= n_cfg;
      sdio_oe_o <= n_busy & ~n_cfg.use_sdo;
      sdio_o    <= n_busy & ~n_cfg.use_sdo & bit_val;
      sdo_oe_o  <= n_busy & n_cfg.use_sdo;
      sdo_o     <= n_busy & n_cfg.use_sdo & bit_val;
    end
  end
endmodule

// File: rtl/ro_serial_readout.sv
module ro_serial_readout
  import ro_readout_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_vld_i,
  input  logic              cfg_offset_i,
  input  logic              cfg_unipolar_i,
  input  logic              cfg_lsb_byte_first_i,
  input  logic              cfg_lsb_bit_first_i,
  input  logic              cfg_use_sdo_i,
  input  logic              rd_start_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  rd_count_i,
  input  logic              sclk_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [DATA_W-1:0] dor_q;
  logic [ADDR_W-1:0] look_addr;
  logic [7:0]        look_byte;
  logic              hold;
  logic              busy;
  rd_cfg_t           rd_cfg;

  assign rd_cfg = '{lsb_byte_first: cfg_lsb_byte_first_i,
                    lsb_bit_first:  cfg_lsb_bit_first_i,
                    use_sdo:        cfg_use_sdo_i};

  ro_format #(.DATA_W(DATA_W)) u_format (
    .clk_i(clk_i), .rst_i(rst_i), .res_i(result_i), .vld_i(result_vld_i),
    .offset_i(cfg_offset_i), .unipolar_i(cfg_unipolar_i), .hold_i(hold),
    .dor_o(dor_q)
  );

  ro_bytesel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bytesel (
    .dor_i(dor_q), .addr_i(look_addr), .byte_o(look_byte)
  );

  ro_shifter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shifter (
    .clk_i(clk_i), .rst_i(rst_i), .sclk_i(sclk_i), .start_i(rd_start_i),
    .start_addr_i(rd_addr_i), .count_i(rd_count_i), .cfg_i(rd_cfg),
    .byte_i(look_byte), .look_addr_o(look_addr), .hold_o(hold),
    .busy_o(busy), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );
endmodule

// File: rtl/ro_readout_chk.sv
module ro_readout_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              sclk_i,
  input logic              busy,
  input logic [DATA_W-1:0] dor_q,
  input logic              sdio_o,
  input logic              sdio_oe_o,
  input logic              sdo_o,
  input logic              sdo_oe_o
);
  assert_oe_exclusive_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({sdio_oe_o, sdo_oe_o}) <= 1);

  assert_dor_held_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && $past(busy)) |-> $stable(dor_q));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy |-> (!sdio_oe_o && !sdo_oe_o && !sdio_o && !sdo_o));

  assert_sdio_on_fall_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (sdio_oe_o && $past(sdio_oe_o) && !$stable(sdio_o)) |->
      ($past(sclk_i, 2) && !$past(sclk_i)));

  assert_sdo_on_fall_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |->
      ($past(sclk_i, 2) && !$past(sclk_i)));
endmodule

bind ro_serial_readout ro_readout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .sclk_i(sclk_i), .busy(busy), .dor_q(dor_q),
  .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/ro_serial_readout_bench.sv
module ro_serial_readout_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] result = '0;
  logic        vld = 1'b0, fmt = 1'b0, uni = 1'b0;
  logic        bd = 1'b0, bitf = 1'b0, pin = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  addr = '0;
  logic [2:0]  cnt = '0;
  logic        sclk = 1'b0;
  logic        sdio, sdio_oe, sdo, sdo_oe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ro_serial_readout u_ro_serial_readout (
    .clk_i(clk), .rst_i(rst), .result_i(result), .result_vld_i(vld),
    .cfg_offset_i(fmt), .cfg_unipolar_i(uni), .cfg_lsb_byte_first_i(bd),
    .cfg_lsb_bit_first_i(bitf), .cfg_use_sdo_i(pin), .rd_start_i(start),
    .rd_addr_i(addr), .rd_count_i(cnt), .sclk_i(sclk), .sdio_o(sdio),
    .sdio_oe_o(sdio_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  typedef struct packed {
    logic [23:0] res;
    logic        fmt, uni, bd, bitf, pin;
    logic [1:0]  addr;
    logic [2:0]  cnt;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{24'h7FFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h7FFFFF}, // R1
    '{24'h800000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h800000}, // R1
    '{24'h000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h800000}, // R2
    '{24'h7FFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'hFFFFFF}, // R2
    '{24'h800000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h000000}, // R2
    '{24'h812345, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h000000}, // R3
    '{24'h812345, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h800000}, // R3
    '{24'h123456, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 24'h123456}, // R3
    '{24'h123456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 3'd3, 24'h563412}, // R6
    '{24'h123456, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd3, 24'h482C6A}, // R7
    '{24'hA5C33C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 24'hA5C33C}, // R8
    '{24'hA5C33C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd1, 24'h0000C3}, // R5
    '{24'hA5C33C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 3'd2, 24'h003C00}, // R5
    '{24'hA5C33C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 3'd2, 24'h00A500}  // R6
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] r, input logic f, input logic u);
    @(negedge clk);
    result = r; fmt = f; uni = u; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // mid_bit < 0 disables the mid-read result pulse
  task automatic read_out(input logic [1:0] a, input logic [2:0] n, input logic b,
                          input logic bo, input logic p, input int mid_bit,
                          input logic [23:0] mid_val,
                          output logic [23:0] acc, output logic oe_bad);
    acc = '0; oe_bad = 1'b0;
    @(negedge clk);
    addr = a; cnt = n; bd = b; bitf = bo; pin = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    for (int k = 0; k < int'(n) * 8; k++) begin
      if (p ? !(sdo_oe && !sdio_oe) : !(sdio_oe && !sdo_oe)) oe_bad = 1'b1;
      acc = {acc[22:0], (p ? sdo : sdio)};
      sclk = 1'b1;
      if (k == mid_bit) begin
        result = mid_val; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        repeat (3) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic        bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state, pins quiet
    check("R10 reset enables/data", {20'd0, sdio_oe, sdo_oe, sdio, sdo}, 24'd0);
    read_out(2'd0, 3'd3, 1'b0, 1'b0, 1'b0, -1, 24'd0, got, bad);
    check("R1 reset register reads zero", got, 24'd0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].res, VECS[i].fmt, VECS[i].uni);
      read_out(VECS[i].addr, VECS[i].cnt, VECS[i].bd, VECS[i].bitf,
               VECS[i].pin, -1, 24'd0, got, bad);
      check($sformatf("R1-R8 vector %0d data", i), got, VECS[i].exp);
      check($sformatf("R8 vector %0d pin enables", i), {23'd0, bad}, 24'd0);
      @(negedge clk);
      check("R10 enables drop after read", {22'd0, sdio_oe, sdo_oe}, 24'd0);
    end

    // R4: clamp then clear unipolar; next conversion is bipolar
    load(24'h812345, 1'b0, 1'b1);
    load(24'h812345, 1'b0, 1'b0);
    read_out(2'd0, 3'd3, 1'b0, 1'b0, 1'b0, -1, 24'd0, got, bad);
    check("R4 bipolar after unipolar cleared", got, 24'h812345);

    // R5: ascending wrap from address 3 to 0
    load(24'hA5C33C, 1'b0, 1'b0);
    read_out(2'd3, 3'd2, 1'b0, 1'b0, 1'b0, -1, 24'd0, got, bad);
    check("R5 wrap 3 to 0", got, 24'h0000A5);

    // R9: result arriving mid-read is deferred
    load(24'h111111, 1'b0, 1'b0);
    read_out(2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 10, 24'h222222, got, bad);
    check("R9 read stays on one conversion", got, 24'h111111);
    read_out(2'd0, 3'd3, 1'b0, 1'b0, 1'b0, -1, 24'd0, got, bad);
    check("R9 deferred result loaded after read", got, 24'h222222);

    // R8: dedicated pin with LSB-first bits
    load(24'h0F0180, 1'b0, 1'b0);
    read_out(2'd0, 3'd3, 1'b0, 1'b1, 1'b1, -1, 24'd0, got, bad);
    check("R7 R8 lsb-first on dedicated pin", got, 24'hF08001);
    check("R8 shared pin enable low", {23'd0, bad}, 24'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule